// File: doc/BRIEF.md
# Accumulator Adjust and Rotate Unit

This unit performs the single-operand accumulator operations of an 8-bit processor datapath: binary-coded-decimal correction after an add or a subtract, the four one-bit accumulator rotates, bitwise complement, two's-complement negation, and the set-carry and invert-carry operations. It takes the current accumulator and flag byte together with an encoded operation code. It computes the new accumulator and flag byte, including the two undocumented flag bits that mirror bits 3 and 5 of a defined operand.

The result is captured in output registers when the enable input is high, so the unit can sit in a pipelined execute stage. An internal adder/subtractor supplies the arithmetic that decimal correction and negation need. No other arithmetic operations are provided.

Top module: `acc_unit`

## Requirements
- R1: A high `rst` at a rising clock edge clears `a_out` and `f_out` to 0x00 at that edge.
- R2: While `en` is low, `a_out` and `f_out` keep their values. Operation codes 9 to 15 copy `a_in` to `a_out` and `f_in` to `f_out` unchanged.
- R3: Decimal adjust (code 0) uses the flag byte layout S=bit7, Z=bit6, copy5=bit5, H=bit4, copy3=bit3, P/V=bit2, N=bit1, C=bit0. Its correction is 0x06 when H is set or the low nibble of A exceeds 9. The correction also gains 0x60 when C is set or A exceeds 0x99. The correction is subtracted from A when N is set and added otherwise.
- R4: After decimal adjust, C is the old C OR (A > 0x99 on the original A), and P/V is 1 when the result has an even number of ones. N is kept. H is the nibble carry (add) or nibble borrow (subtract) of the correction step. S, Z, bit 5 and bit 3 come from the result.
- R5: Rotate left circular (code 1) moves A bit 7 into bit 0 and into C. Rotate right circular (code 2) moves A bit 0 into bit 7 and into C.
- R6: Rotate left through carry (code 3) shifts the old C into bit 0 and old bit 7 into C. Rotate right through carry (code 4) shifts the old C into bit 7 and old bit 0 into C.
- R7: All four rotates keep S, Z and P/V, clear H and N, and copy bits 3 and 5 of the new A into the flags.
- R8: Complement (code 5) inverts A and sets H and N. It keeps C, P/V, Z and S, and copies bits 3 and 5 of the new A.
- R9: Negate (code 6) gives A = 0 - A with N=1. C is set when A was nonzero, H when the low nibble of A was nonzero, and P/V when A was 0x80. S, Z, bit 5 and bit 3 come from the result.
- R10: Set carry (code 7) leaves A unchanged, sets C, and clears H and N. It keeps S, Z and P/V and copies bits 3 and 5 of A.
- R11: Invert carry (code 8) leaves A unchanged, moves the old C into H, inverts C, and clears N. It keeps S, Z and P/V and copies bits 3 and 5 of A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Result capture enable |
| op_sel | input | 4 | Operation code |
| a_in | input | 8 | Accumulator operand |
| f_in | input | 8 | Flag byte operand |
| a_out | output | 8 | Registered new accumulator |
| f_out | output | 8 | Registered new flag byte |

## Verification
The bench builds the unit at its only meaningful data width, 8 bits, the width at which decimal correction is defined. At that width the full decimal-adjust input space is small enough to cover completely: every accumulator value with every combination of C, H and N, 2048 cases. The other operations are driven with boundary accumulator values (0x00, 0x01, 0x7F, 0x80, 0xFF) and with flag bytes that have all flags clear, all set, or only carry set. Disabled cycles, unused codes and a mid-run reset are also exercised.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int DW = 8;

  localparam int FB_C  = 0;
  localparam int FB_N  = 1;
  localparam int FB_PV = 2;
  localparam int FB_X3 = 3;
  localparam int FB_H  = 4;
  localparam int FB_X5 = 5;
  localparam int FB_Z  = 6;
  localparam int FB_S  = 7;

  localparam logic [DW-1:0] KEEP_SZP = (DW'(1) << FB_S) | (DW'(1) << FB_Z) | (DW'(1) << FB_PV);
  localparam logic [DW-1:0] COPY_35  = (DW'(1) << FB_X5) | (DW'(1) << FB_X3);

  typedef enum logic [3:0] {
    OP_DADJ = 4'd0,
    OP_RLC  = 4'd1,
    OP_RRC  = 4'd2,
    OP_RL   = 4'd3,
    OP_RR   = 4'd4,
    OP_CPL  = 4'd5,
    OP_NEG  = 4'd6,
    OP_SCF  = 4'd7,
    OP_CCF  = 4'd8
  } acc_op_e;
endpackage

// File: rtl/acc_addsub.sv
module acc_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] r,
  output logic         c_out,
  output logic         h_out,
  output logic         v_out
);
  localparam int NIB = W / 2;

  logic [W-1:0] y_eff;
  logic [W:0]   full;
  logic [NIB:0] half;

  always_comb begin
    y_eff = sub ? ~y : y;
    full  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, sub};
    half  = {1'b0, x[NIB-1:0]} + {1'b0, y_eff[NIB-1:0]} + {{NIB{1'b0}}, sub};
    r     = full[W-1:0];
    c_out = full[W] ^ sub;
    h_out = half[NIB] ^ sub;
    v_out = (x[W-1] == y_eff[W-1]) && (r[W-1] != x[W-1]);
  end
endmodule

// File: rtl/acc_decadj.sv
module acc_decadj
  import acc_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] f,
  output logic [DW-1:0] a_new,
  output logic [DW-1:0] f_new
);
  logic [DW-1:0] corr;
  logic          hi_big;
  logic          c_unused;
  logic          v_unused;
  logic          h_step;
  logic [DW-1:0] res;

  always_comb begin
    hi_big = (a > 8'h99);
    corr   = '0;
    if (f[FB_H] || (a[3:0] > 4'd9)) corr[3:0] = 4'h6;
    if (f[FB_C] || hi_big)          corr[7:4] = 4'h6;
  end

  acc_addsub #(.W(DW)) u_adj (
    .x(a), .y(corr), .sub(f[FB_N]),
    .r(res), .c_out(c_unused), .h_out(h_step), .v_out(v_unused)
  );

  always_comb begin
    a_new        = res;
    f_new        = '0;
    f_new[FB_S]  = res[DW-1];
    f_new[FB_Z]  = (res == '0);
    f_new[FB_X5] = res[5];
    f_new[FB_X3] = res[3];
    f_new[FB_H]  = h_step;
    f_new[FB_PV] = ~^res;
    f_new[FB_N]  = f[FB_N];
    f_new[FB_C]  = f[FB_C] | hi_big;
  end
endmodule

// File: rtl/acc_rotate.sv
module acc_rotate
  import acc_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic          cin,
  input  logic          right,
  input  logic          thru,
  output logic [DW-1:0] r,
  output logic          cout
);
  logic fill;

  always_comb begin
    if (thru)       fill = cin;
    else if (right) fill = a[0];
    else            fill = a[DW-1];
    if (right) begin
      r    = {fill, a[DW-1:1]};
      cout = a[0];
    end else begin
      r    = {a[DW-2:0], fill};
      cout = a[DW-1];
    end
  end
endmodule

// File: rtl/acc_unit.sv
module acc_unit
  import acc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [3:0]    op_sel,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] f_in,
  output logic [DW-1:0] a_out,
  output logic [DW-1:0] f_out
);
  logic [DW-1:0] da_a, da_f;
  logic [DW-1:0] rot_a;
  logic          rot_c;
  logic [DW-1:0] neg_r;
  logic          neg_c, neg_h, neg_v;
  logic          is_right, is_thru;
  logic [DW-1:0] a_nx, f_nx;

  assign is_right = (op_sel == OP_RRC) || (op_sel == OP_RR);
  assign is_thru  = (op_sel == OP_RL)  || (op_sel == OP_RR);

  acc_decadj u_dadj (.a(a_in), .f(f_in), .a_new(da_a), .f_new(da_f));

  acc_rotate u_rot (
    .a(a_in), .cin(f_in[FB_C]), .right(is_right), .thru(is_thru),
    .r(rot_a), .cout(rot_c)
  );

  acc_addsub #(.W(DW)) u_neg (
    .x('0), .y(a_in), .sub(1'b1),
    .r(neg_r), .c_out(neg_c), .h_out(neg_h), .v_out(neg_v)
  );

  always_comb begin
    a_nx = a_in;
    f_nx = f_in;
    case (op_sel)
      OP_DADJ: begin
        a_nx = da_a;
        f_nx = da_f;
      end
      OP_RLC, OP_RRC, OP_RL, OP_RR: begin
        a_nx        = rot_a;
        f_nx        = (f_in & KEEP_SZP) | (rot_a & COPY_35);
        f_nx[FB_C]  = rot_c;
      end
      OP_CPL: begin
        a_nx        = ~a_in;
        f_nx        = (f_in & (KEEP_SZP | DW'(1))) | (~a_in & COPY_35);
        f_nx[FB_H]  = 1'b1;
        f_nx[FB_N]  = 1'b1;
      end
      OP_NEG: begin
        a_nx         = neg_r;
        f_nx         = '0;
        f_nx[FB_S]   = neg_r[DW-1];
        f_nx[FB_Z]   = (neg_r == '0);
        f_nx[FB_X5]  = neg_r[5];
        f_nx[FB_X3]  = neg_r[3];
        f_nx[FB_H]   = neg_h;
        f_nx[FB_PV]  = neg_v;
        f_nx[FB_N]   = 1'b1;
        f_nx[FB_C]   = neg_c;
      end
      OP_SCF: begin
        f_nx        = (f_in & KEEP_SZP) | (a_in & COPY_35);
        f_nx[FB_C]  = 1'b1;
      end
      OP_CCF: begin
        f_nx        = (f_in & KEEP_SZP) | (a_in & COPY_35);
        f_nx[FB_H]  = f_in[FB_C];
        f_nx[FB_C]  = ~f_in[FB_C];
      end
      default: begin
        a_nx = a_in;
        f_nx = f_in;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out <= '0;
      f_out <= '0;
    end else if (en) begin
      a_out <= a_nx;
      f_out <= f_nx;
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> ($stable(a_out) && $stable(f_out))); // R2
  AST_DADJ_CARRY: assert property (@(posedge clk) disable iff (rst)
    (en && op_sel == OP_DADJ) |=> (f_out[FB_C] == ($past(f_in[FB_C]) || ($past(a_in) > 8'h99)))); // R4
  AST_ROT_KEEP_SZP: assert property (@(posedge clk) disable iff (rst)
    (en && op_sel >= OP_RLC && op_sel <= OP_RR) |=> ((f_out & KEEP_SZP) == ($past(f_in) & KEEP_SZP) && !f_out[FB_H] && !f_out[FB_N])); // R7
  AST_NEG_SETS_N: assert property (@(posedge clk) disable iff (rst)
    (en && op_sel == OP_NEG) |=> (f_out[FB_N] && (a_out + $past(a_in) == 8'h00))); // R9
  AST_SCF_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (en && op_sel == OP_SCF) |=> (f_out[FB_C] && !f_out[FB_H] && !f_out[FB_N])); // R10
  AST_CCF_SWAP: assert property (@(posedge clk) disable iff (rst)
    (en && op_sel == OP_CCF) |=> (f_out[FB_C] == !$past(f_in[FB_C]) && f_out[FB_H] == $past(f_in[FB_C]))); // R11
endmodule

// File: tb/test_acc_unit.sv
`timescale 1ns/1ps
module test_acc_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [3:0] op_sel = 4'd0;
  logic [7:0] a_in = 8'h00;
  logic [7:0] f_in = 8'h00;
  logic [7:0] a_out, f_out;

  int checks = 0;
  int fails = 0;
  bit running = 1'b0;
  bit done = 1'b0;
  int exp_a = 0;
  int exp_f = 0;
  string exp_tag = "R1";

  always #4 clk = ~clk;

  acc_unit i_acc_unit (
    .clk(clk), .rst(rst), .en(en), .op_sel(op_sel),
    .a_in(a_in), .f_in(f_in), .a_out(a_out), .f_out(f_out)
  );

  function automatic int ones(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0: return "R3/R4";
      1, 2: return "R5/R7";
      3, 4: return "R6/R7";
      5: return "R8";
      6: return "R9";
      7: return "R10";
      8: return "R11";
      default: return "R2";
    endcase
  endfunction

  // behavioural model: returns {new_a, new_f}
  function automatic int model(int op, int a, int f);
    int na = a, nf = f, corr, r, h, c;
    case (op)
      0: begin
        corr = 0;
        if ((f & 16) != 0 || (a % 16) > 9) corr = 6;
        if ((f & 1) != 0 || a > 153) corr += 96;
        if ((f & 2) != 0) begin
          r = (a - corr + 256) % 256;
          h = ((a % 16) < (corr % 16)) ? 1 : 0;
        end else begin
          r = (a + corr) % 256;
          h = ((a % 16) + (corr % 16) > 15) ? 1 : 0;
        end
        c = ((f & 1) != 0 || a > 153) ? 1 : 0;
        na = r;
        nf = (r & 168) | (r == 0 ? 64 : 0) | (h * 16) | ((ones(r) % 2 == 0) ? 4 : 0) | (f & 2) | c;
      end
      1: begin na = ((a * 2) % 256) + (a / 128); nf = (f & 196) | (na & 40) | (a / 128); end
      2: begin na = (a / 2) + (a % 2) * 128;     nf = (f & 196) | (na & 40) | (a % 2); end
      3: begin na = ((a * 2) % 256) + (f % 2);   nf = (f & 196) | (na & 40) | (a / 128); end
      4: begin na = (a / 2) + (f % 2) * 128;     nf = (f & 196) | (na & 40) | (a % 2); end
      5: begin na = 255 - a; nf = (f & 197) | 18 | (na & 40); end
      6: begin
        na = (256 - a) % 256;
        nf = (na & 168) | (na == 0 ? 64 : 0) | ((a % 16) != 0 ? 16 : 0) |
             (a == 128 ? 4 : 0) | 2 | (a != 0 ? 1 : 0);
      end
      7: nf = (f & 196) | (a & 40) | 1;
      8: nf = (f & 196) | (a & 40) | ((f & 1) != 0 ? 16 : 1);
      default: begin na = a; nf = f; end
    endcase
    return na * 256 + nf;
  endfunction

  always @(posedge clk) begin
    int res;
    if (rst) begin
      exp_a = 0; exp_f = 0; exp_tag = "R1";
    end else if (en) begin
      res = model(int'(op_sel), int'(a_in), int'(f_in));
      exp_a = res / 256; exp_f = res % 256; exp_tag = tag_of(int'(op_sel));
    end else begin
      exp_tag = "R2";
    end
  end

  always @(negedge clk) begin
    if (running && !done) begin
      checks++;
      if (int'(a_out) != exp_a || int'(f_out) != exp_f) begin
        fails++;
        $display("FAIL %s: a_out=%02h f_out=%02h expected a=%02h f=%02h",
                 exp_tag, a_out, f_out, exp_a[7:0], exp_f[7:0]);
      end
    end
  end

  task automatic step(input int op, input int a, input int f, input bit e);
    @(negedge clk);
    op_sel = 4'(op); a_in = 8'(a); f_in = 8'(f); en = e;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int pats[6] = '{0, 1, 127, 128, 255, 90};
    int fpats[3] = '{0, 255, 1};
    @(posedge clk);
    running = 1'b1;
    repeat (3) @(posedge clk);       // R1 reset state checked each cycle
    @(negedge clk); rst = 1'b0;
    // R3 R4: full decimal adjust sweep
    for (int a = 0; a < 256; a++)
      for (int fl = 0; fl < 8; fl++)
        step(0, a, ((fl & 1) ? 1 : 0) | ((fl & 2) ? 2 : 0) | ((fl & 4) ? 16 : 0) | (a & 196), 1'b1);
    // R5..R11 across boundary patterns
    for (int op = 1; op <= 8; op++) begin
      for (int p = 0; p < 6; p++)
        for (int q = 0; q < 3; q++)
          step(op, pats[p], fpats[q], 1'b1);
      for (int a = 3; a < 256; a += 37) step(op, a, a ^ 85, 1'b1);
    end
    // R2: disabled cycles with changing inputs, then unused codes
    step(6, 18, 0, 1'b1);
    for (int k = 0; k < 10; k++) step(k % 9, k * 23, k * 41, 1'b0);
    for (int op = 9; op < 16; op++) step(op, op * 17, 255 - op, 1'b1);
    // R1: mid-run reset
    step(5, 60, 0, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; en = 1'b0;
    step(0, 154, 0, 1'b1);
    step(0, 0, 0, 1'b0);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule